// File: doc/BRIEF.md
# Motor stall detection monitor

This block watches how quickly the motor current builds up. During each quadrant of motor drive it adds up the current-rise times that a measurement front end reports. At the strobe that marks the end of the quadrant, it compares that total with an 8-bit minimum-time threshold.

A total below the threshold means the current rose too fast, which points to a stalled rotor. In that case the block sets a sticky stall flag. The flag stays set until a clear pulse arrives.

An output pin normally carries the bridge A PWM control signal. Setting a select input routes the stall flag onto that pin instead, so a supervisor can see a stall without a register read. Producing the rise-time values from the analog current is done elsewhere.

Top module: `stall_mon`

## Requirements
- R1: After reset, `stall` is 0 and the running sum is empty, so the first quadrant starts from zero.
- R2: The quadrant sum is the total of `rise_len` over every cycle with `rise_valid` high, from the cycle after the previous `quad_end` up to and including the cycle of the current `quad_end`. The next quadrant starts from zero.
- R3: The sum saturates at 2^SUM_W-1 and never wraps.
- R4: In a `quad_end` cycle, the completed sum and `thresh` are compared as unsigned values. If the sum is strictly less, `stall` is 1 from the next cycle. A sum equal to or greater than `thresh` leaves `stall` unchanged.
- R5: `stall` is set only by a `quad_end` comparison. Once set, it stays set through later quadrants whatever their sums.
- R6: A `stall_clr` pulse makes `stall` 0 from the next cycle. If a set condition (R4) occurs in the same cycle, the set wins.
- R7: `pwm_pin` equals `bridge_pwm` when `sel_stall` is 0 and equals `stall` when `sel_stall` is 1, with no register delay.
- R8: `thresh` matters only in the `quad_end` cycle. Its value during the rest of the quadrant has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rise_valid | input | 1 | A rise-time value is present this cycle |
| rise_len | input | RISE_W | Rise-time value to add |
| quad_end | input | 1 | Last cycle of the quadrant; compare and restart |
| thresh | input | THR_W | Minimum allowed quadrant total |
| stall_clr | input | 1 | Clear pulse for the stall flag |
| sel_stall | input | 1 | 0: pin carries bridge PWM, 1: pin carries stall flag |
| bridge_pwm | input | 1 | Bridge A PWM control signal |
| stall | output | 1 | Sticky stall flag |
| pwm_pin | output | 1 | Selected PWM pin level |

## Verification
A sweep crosses sample counts from zero to five with lengths of 0, 1, 99, 100 and 255, against thresholds that straddle each resulting total. This separates strict "less than" from "less or equal" and shows each quadrant starting empty.

Five samples of 255 overflow a 10-bit sum. The saturated total of 1023 does not trip a threshold of 252, whereas a wrapped total of 251 would.

Directed cases cover the following:
- a sample landing in the strobe cycle;
- a threshold that changes mid-quadrant;
- a clear coinciding with a set;
- a passing quadrant following a stall;
- all eight combinations of select, PWM level and flag on the pin.

// File: rtl/stall_mon.sv
module stall_mon #(
  parameter int RISE_W = 8,
  parameter int SUM_W  = 10,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_valid,
  input  logic [RISE_W-1:0] rise_len,
  input  logic              quad_end,
  input  logic [THR_W-1:0]  thresh,
  input  logic              stall_clr,
  input  logic              sel_stall,
  input  logic              bridge_pwm,
  output logic              stall,
  output logic              pwm_pin
);

  localparam int CW = (SUM_W > THR_W) ? SUM_W : THR_W;
  localparam logic [SUM_W-1:0] SUM_MAX = {SUM_W{1'b1}};

  logic [SUM_W-1:0] acc;
  logic [SUM_W:0]   add_full;
  logic [SUM_W-1:0] acc_add;
  logic [SUM_W-1:0] total;
  logic             too_short;

  assign add_full  = {1'b0, acc} + (SUM_W+1)'(rise_len);
  assign acc_add   = add_full[SUM_W] ? SUM_MAX : add_full[SUM_W-1:0];
  assign total     = rise_valid ? acc_add : acc;
  assign too_short = CW'(total) < CW'(thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc <= '0;
    else if (quad_end)   acc <= '0;
    else if (rise_valid) acc <= acc_add;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      stall <= 1'b0;
    else if (quad_end && too_short)  stall <= 1'b1;
    else if (stall_clr)              stall <= 1'b0;
  end

  assign pwm_pin = sel_stall ? stall : bridge_pwm;

  AST_ACC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    quad_end |=> acc == '0); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_valid && !quad_end) |=> acc >= $past(acc)); // R3
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == SUM_MAX && !quad_end) |=> acc == SUM_MAX); // R3
  AST_SET_ON_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_end && too_short) |=> stall); // R4
  AST_SET_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !quad_end) |=> !stall); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !stall_clr) |=> stall); // R5
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_clr && !quad_end) |=> !stall); // R6

endmodule

// File: tb/stall_mon_tb.sv
module stall_mon_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rise_valid = 1'b0;
  logic [7:0] rise_len = '0;
  logic quad_end = 1'b0;
  logic [7:0] thresh = '0;
  logic stall_clr = 1'b0;
  logic sel_stall = 1'b0;
  logic bridge_pwm = 1'b0;
  logic stall, pwm_pin;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stall_mon u_dut (
    .clk(clk), .rst_n(rst_n), .rise_valid(rise_valid), .rise_len(rise_len),
    .quad_end(quad_end), .thresh(thresh), .stall_clr(stall_clr),
    .sel_stall(sel_stall), .bridge_pwm(bridge_pwm),
    .stall(stall), .pwm_pin(pwm_pin));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    stall_clr = 1'b1;
    @(negedge clk);
    stall_clr = 1'b0;
  endtask

  task automatic quad(int k, int len, int thr);
    thresh = 8'(thr);
    for (int i = 0; i < k; i++) begin
      rise_valid = 1'b1;
      rise_len = 8'(len);
      @(negedge clk);
    end
    rise_valid = 1'b0;
    quad_end = 1'b1;
    @(negedge clk);
    quad_end = 1'b0;
  endtask

  initial begin
    int lens[5] = '{0, 1, 99, 100, 255};
    int thrs[8] = '{0, 1, 2, 50, 100, 101, 254, 255};
    int sum;
    repeat (3) @(negedge clk);
    check("R1 stall after reset", stall, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 stall idle", stall, 0);
    quad(1, 5, 6);
    check("R1 first quadrant from zero", stall, 1);
    clear_flag();
    check("R6 clear", stall, 0);

    for (int t = 0; t < 8; t++)
      for (int k = 0; k <= 5; k++)
        for (int l = 0; l < 5; l++) begin
          sum = k * lens[l];
          if (sum > 1023) sum = 1023;
          quad(k, lens[l], thrs[t]);
          check((k == 5 && l == 4) ? "R3 saturated sum" : "R2 R4 sweep",
                stall, (sum < thrs[t]) ? 1 : 0);
          clear_flag();
        end

    quad(5, 255, 252);
    check("R3 no wrap", stall, 0);
    quad(2, 255, 255);
    check("R2 restart after saturation", stall, 0);

    // R2: the sample in the strobe cycle belongs to the closing quadrant
    thresh = 8'd20;
    rise_valid = 1'b1; rise_len = 8'd10; @(negedge clk);
    rise_len = 8'd10; quad_end = 1'b1; @(negedge clk);
    quad_end = 1'b0; rise_valid = 1'b0;
    check("R2 strobe sample counted", stall, 0);
    quad(0, 0, 1);
    check("R2 strobe sample not carried", stall, 1);
    clear_flag();

    // R8: threshold changes mid-quadrant do not count
    thresh = 8'd255;
    rise_valid = 1'b1; rise_len = 8'd3; @(negedge clk);
    rise_valid = 1'b0; @(negedge clk);
    check("R8 no set mid-quadrant", stall, 0);
    thresh = 8'd3; quad_end = 1'b1; @(negedge clk);
    quad_end = 1'b0;
    check("R8 threshold at strobe", stall, 0);

    quad(1, 1, 200);
    check("R5 set", stall, 1);
    quad(3, 255, 10);
    check("R5 sticky over passing quadrant", stall, 1);
    clear_flag();
    check("R6 clear after sticky", stall, 0);

    thresh = 8'd9; quad_end = 1'b1; stall_clr = 1'b1; @(negedge clk);
    quad_end = 1'b0; stall_clr = 1'b0;
    check("R6 set wins over clear", stall, 1);

    for (int c = 0; c < 8; c++) begin
      clear_flag();
      if (c[2]) quad(0, 0, 1);
      sel_stall = c[0]; bridge_pwm = c[1];
      #1;
      check("R7 pin select", pwm_pin, c[0] ? (c[2] ? 1 : 0) : (c[1] ? 1 : 0));
      @(negedge clk);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule